// File: doc/BRIEF.md
# Elastic Bit Buffer with Adaptive Read Pacing

This block takes a 1.544 Mb/s serial bit stream whose strobes arrive unevenly, with jitter, gaps or bursts. It passes the bits on at a steady rate. Each accepted bit is written into a small elastic store. Bits are read back out on a strobe made by dividing a 24.704 MHz master clock. The whole block runs on that one clock.

The divider normally counts 16 master cycles per output bit. If the store drifts close to full, the divider shortens the next period to 15. If the store drifts close to empty, it stretches the next period to 17. Either correction sets a sticky status flag, which stays set until a one-cycle clear pulse.

Three control inputs set up the block. One picks the store size: a small store for low delay, or a large one for heavy wander. One picks which of two input streams (receive or transmit) feeds the store. The third bypasses the store, so the selected input is sent straight to the output.

Top module: `jitter_smoother`

## Requirements
- R1: When `path_sel` is 0, `rx_bit`/`rx_stb` feed the store. When it is 1, `tx_bit`/`tx_stb` feed it. The unselected pair has no effect on the output.
- R2: When `deep_mode` is 0 the store holds 32 bits; when it is 1 it holds 128. After a re-centre the store holds half its size in stale entries. The first bit written after the re-centre comes out on output strobe number depth/2 + 1.
- R3: Accepted bits leave in the order they were written, with none lost or repeated. This holds for gapped or bursty input whose average rate matches the output rate.
- R4: Fill is the count of bits written minus bits read, taken in the cycle where an output period ends. When the fill lies between the two limits, the next period is 16 cycles.
- R5: When the fill exceeds depth minus margin (above 28 for the 32-bit store, above 120 for the 128-bit store), the next period is 15 cycles.
- R6: When the fill is below the margin (below 4 for the 32-bit store, below 8 for the 128-bit store), the next period is 17 cycles.
- R7: The period length changes only when a period completes. Every interval between output strobes is 15, 16 or 17 cycles.
- R8: `trip_flag` goes to 1 on the clock edge that ends a period whose successor is 15 or 17 cycles. It then stays at 1.
- R9: A one-cycle `trip_clr` pulse clears `trip_flag` on the next edge. If a new trip falls on the same edge as the clear, the flag stays at 1.
- R10: While `bypass` is 1, `out_stb`/`out_bit` equal the selected input strobe and bit, delayed by one cycle.
- R11: A re-centre happens on reset, on any change of `deep_mode` or `path_sel`, and on every cycle that `bypass` is 1. A re-centre drops any write in that cycle and resets the divider to 16. The first output strobe then follows 16 cycles after the re-centring edge.
- R12: On the edge after reset is applied, `out_stb` and `trip_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24.704 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| path_sel | input | 1 | 0: receive stream feeds the store, 1: transmit stream |
| deep_mode | input | 1 | 0: 32-bit store, 1: 128-bit store |
| bypass | input | 1 | 1: selected input goes straight to the output |
| trip_clr | input | 1 | One-cycle pulse that clears the limit flag |
| rx_bit | input | 1 | Receive-side data bit |
| rx_stb | input | 1 | Receive-side write strobe |
| tx_bit | input | 1 | Transmit-side data bit |
| tx_stb | input | 1 | Transmit-side write strobe |
| out_bit | output | 1 | Output data bit, valid with `out_stb` |
| out_stb | output | 1 | Smoothed output strobe |
| trip_flag | output | 1 | Sticky flag, set when a 15 or 17 period is chosen |

## Verification
A pointer that is off by one shows up at the output within one output period. It appears either as a wrong bit in the output sequence or as the wrong period choice, because the bench predicts every period from its own fill count. A divider state that is wrong gives an interval other than the predicted 15, 16 or 17 on the very next strobe. A flag that is wrong is caught within one cycle, because the flag is compared on every cycle. A missing re-centre shows up as a first strobe that does not come 16 cycles after the control change, and as stale data arriving out of place.

// File: rtl/jas_pkg.sv
package jas_pkg;

  // Length chosen for the next output period
  typedef enum logic [1:0] {
    PACE_NOM  = 2'd0,  // nominal divide
    PACE_FAST = 2'd1,  // one cycle shorter: drain the store
    PACE_SLOW = 2'd2   // one cycle longer: let the store refill
  } pace_t;

  // Decide the pace from the fill level and the active limits
  function automatic pace_t pick_pace(input int unsigned fill,
                                      input int unsigned depth,
                                      input int unsigned margin);
    if (fill > depth - margin) return PACE_FAST;
    if (fill < margin)         return PACE_SLOW;
    return PACE_NOM;
  endfunction

endpackage

// File: rtl/jas_ingress.sv
// Input stream selection, registered bypass path and re-centre detection
module jas_ingress (
  input  logic clk,
  input  logic rst,
  input  logic path_sel,
  input  logic deep_mode,
  input  logic bypass,
  input  logic rx_bit,
  input  logic rx_stb,
  input  logic tx_bit,
  input  logic tx_stb,
  output logic sel_bit,
  output logic sel_stb,
  output logic restart,
  output logic byp_on_q,
  output logic byp_bit_q,
  output logic byp_stb_q
);

  logic mode_q;
  logic path_q;

  assign sel_bit = path_sel ? tx_bit : rx_bit;
  assign sel_stb = path_sel ? tx_stb : rx_stb;

  // Any reconfiguration re-centres the store and the divider
  assign restart = rst | bypass | (deep_mode != mode_q) | (path_sel != path_q);

  always_ff @(posedge clk) begin
    mode_q <= deep_mode;
    path_q <= path_sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_on_q  <= 1'b0;
      byp_stb_q <= 1'b0;
      byp_bit_q <= 1'b0;
    end else begin
      byp_on_q  <= bypass;
      byp_stb_q <= sel_stb;
      byp_bit_q <= sel_bit;
    end
  end

endmodule

// File: rtl/jas_store.sv
// Elastic bit store: one write port, one registered read port
module jas_store #(
  parameter int unsigned DEPTH_SHALLOW = 32,
  parameter int unsigned DEPTH_DEEP    = 128,
  parameter int unsigned PTR_W         = $clog2(DEPTH_DEEP)
) (
  input  logic             clk,
  input  logic             restart,
  input  logic             deep,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic             rd_en,
  output logic             rd_bit,
  output logic [PTR_W-1:0] fill
);

  localparam logic [PTR_W-1:0] MASK_S = PTR_W'(DEPTH_SHALLOW - 1);
  localparam logic [PTR_W-1:0] MASK_D = PTR_W'(DEPTH_DEEP - 1);
  localparam logic [PTR_W-1:0] HALF_S = PTR_W'(DEPTH_SHALLOW / 2);
  localparam logic [PTR_W-1:0] HALF_D = PTR_W'(DEPTH_DEEP / 2);

  logic             mem [DEPTH_DEEP];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [PTR_W-1:0] mask;
  logic [PTR_W-1:0] half;

  assign mask = deep ? MASK_D : MASK_S;
  assign half = deep ? HALF_D : HALF_S;
  assign fill = (wr_ptr - rd_ptr) & mask;

  // Pointers wrap inside the active depth; restart places them half apart
  always_ff @(posedge clk) begin
    if (restart) begin
      wr_ptr <= half;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr + 1'b1) & mask;
      if (rd_en) rd_ptr <= (rd_ptr + 1'b1) & mask;
    end
  end

  // Plain write port, suited to block RAM
  always_ff @(posedge clk) begin
    if (wr_en && !restart) mem[wr_ptr] <= wr_bit;
  end

  // Registered read with enable, suited to block RAM
  always_ff @(posedge clk) begin
    if (rd_en) rd_bit <= mem[rd_ptr];
  end

endmodule

// File: rtl/jas_pacer.sv
// Variable-ratio divider producing the read strobe
module jas_pacer
  import jas_pkg::*;
#(
  parameter int unsigned DIV_NOM        = 16,
  parameter int unsigned DEPTH_SHALLOW  = 32,
  parameter int unsigned DEPTH_DEEP     = 128,
  parameter int unsigned MARGIN_SHALLOW = 4,
  parameter int unsigned MARGIN_DEEP    = 8,
  parameter int unsigned PTR_W          = $clog2(DEPTH_DEEP),
  parameter int unsigned CNT_W          = $clog2(DIV_NOM + 2)
) (
  input  logic             clk,
  input  logic             restart,
  input  logic             deep,
  input  logic [PTR_W-1:0] fill,
  output logic             tick,
  output logic             adjust,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] last_q
);

  localparam logic [CNT_W-1:0] LAST_NOM  = CNT_W'(DIV_NOM - 1);
  localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(DIV_NOM - 2);
  localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(DIV_NOM);

  pace_t            pace;
  int unsigned      fill_u;
  int unsigned      depth_u;
  int unsigned      margin_u;
  logic [CNT_W-1:0] last_next;

  assign fill_u   = 32'(fill);
  assign depth_u  = deep ? DEPTH_DEEP : DEPTH_SHALLOW;
  assign margin_u = deep ? MARGIN_DEEP : MARGIN_SHALLOW;
  assign pace     = pick_pace(fill_u, depth_u, margin_u);

  always_comb begin
    case (pace)
      PACE_FAST: last_next = LAST_FAST;
      PACE_SLOW: last_next = LAST_SLOW;
      default:   last_next = LAST_NOM;
    endcase
  end

  // A period ends when the count reaches its stored limit
  assign tick   = (cnt_q == last_q) && !restart;
  assign adjust = tick && (pace != PACE_NOM);

  // The limit is reloaded only at period end, so no short strobe appears
  always_ff @(posedge clk) begin
    if (restart) begin
      cnt_q  <= '0;
      last_q <= LAST_NOM;
    end else if (tick) begin
      cnt_q  <= '0;
      last_q <= last_next;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/jas_trip.sv
// Sticky limit flag; a set beats a clear in the same cycle
module jas_trip (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

endmodule

// File: rtl/jitter_smoother.sv
module jitter_smoother #(
  parameter int unsigned DIV_NOM        = 16,
  parameter int unsigned DEPTH_SHALLOW  = 32,
  parameter int unsigned DEPTH_DEEP     = 128,
  parameter int unsigned MARGIN_SHALLOW = 4,
  parameter int unsigned MARGIN_DEEP    = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic path_sel,
  input  logic deep_mode,
  input  logic bypass,
  input  logic trip_clr,
  input  logic rx_bit,
  input  logic rx_stb,
  input  logic tx_bit,
  input  logic tx_stb,
  output logic out_bit,
  output logic out_stb,
  output logic trip_flag
);

  localparam int unsigned PTR_W = $clog2(DEPTH_DEEP);
  localparam int unsigned CNT_W = $clog2(DIV_NOM + 2);

  logic             sel_bit;
  logic             sel_stb;
  logic             restart;
  logic             byp_on_q;
  logic             byp_bit_q;
  logic             byp_stb_q;
  logic             rd_bit;
  logic [PTR_W-1:0] fill;
  logic             fifo_tick;
  logic             trip_set;
  logic [CNT_W-1:0] pace_cnt;
  logic [CNT_W-1:0] pace_last;
  logic             fifo_stb_q;

  jas_ingress u_ingress (
    .clk       (clk),
    .rst       (rst),
    .path_sel  (path_sel),
    .deep_mode (deep_mode),
    .bypass    (bypass),
    .rx_bit    (rx_bit),
    .rx_stb    (rx_stb),
    .tx_bit    (tx_bit),
    .tx_stb    (tx_stb),
    .sel_bit   (sel_bit),
    .sel_stb   (sel_stb),
    .restart   (restart),
    .byp_on_q  (byp_on_q),
    .byp_bit_q (byp_bit_q),
    .byp_stb_q (byp_stb_q)
  );

  jas_store #(
    .DEPTH_SHALLOW (DEPTH_SHALLOW),
    .DEPTH_DEEP    (DEPTH_DEEP),
    .PTR_W         (PTR_W)
  ) u_store (
    .clk     (clk),
    .restart (restart),
    .deep    (deep_mode),
    .wr_en   (sel_stb),
    .wr_bit  (sel_bit),
    .rd_en   (fifo_tick),
    .rd_bit  (rd_bit),
    .fill    (fill)
  );

  jas_pacer #(
    .DIV_NOM        (DIV_NOM),
    .DEPTH_SHALLOW  (DEPTH_SHALLOW),
    .DEPTH_DEEP     (DEPTH_DEEP),
    .MARGIN_SHALLOW (MARGIN_SHALLOW),
    .MARGIN_DEEP    (MARGIN_DEEP),
    .PTR_W          (PTR_W),
    .CNT_W          (CNT_W)
  ) u_pacer (
    .clk     (clk),
    .restart (restart),
    .deep    (deep_mode),
    .fill    (fill),
    .tick    (fifo_tick),
    .adjust  (trip_set),
    .cnt_q   (pace_cnt),
    .last_q  (pace_last)
  );

  jas_trip u_trip (
    .clk  (clk),
    .rst  (rst),
    .set  (trip_set),
    .clr  (trip_clr),
    .flag (trip_flag)
  );

  // Output strobe is registered and lines up with the registered read data
  always_ff @(posedge clk) begin
    if (rst) fifo_stb_q <= 1'b0;
    else     fifo_stb_q <= fifo_tick;
  end

  // Both sources are registers; the select is a registered bypass
  assign out_stb = byp_on_q ? byp_stb_q : fifo_stb_q;
  assign out_bit = byp_on_q ? byp_bit_q : rd_bit;

endmodule

// File: rtl/jas_checker.sv
module jas_checker #(
  parameter int unsigned DIV_NOM = 16,
  parameter int unsigned CNT_W   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             bypass,
  input logic             path_sel,
  input logic             rx_stb,
  input logic             tx_stb,
  input logic             trip_clr,
  input logic             out_stb,
  input logic             trip_flag,
  input logic             tick,
  input logic             adjust,
  input logic             restart,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] last
);

  // R7
  ratio_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(last) >= int'(DIV_NOM) - 2) && (int'(last) <= int'(DIV_NOM)));

  // R7
  ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(last));

  // R8
  trip_set_chk: assert property (@(posedge clk) disable iff (rst)
    adjust |=> trip_flag);

  // R8
  trip_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (trip_flag && !trip_clr) |=> trip_flag);

  // R9
  trip_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (trip_clr && !adjust) |=> !trip_flag);

  // R10
  bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
    bypass |=> (out_stb == $past(path_sel ? tx_stb : rx_stb)));

  // R11
  recentre_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> ((cnt == '0) && (int'(last) == int'(DIV_NOM) - 1)));

  // R12
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!out_stb && !trip_flag));

endmodule

bind jitter_smoother jas_checker #(
  .DIV_NOM (DIV_NOM),
  .CNT_W   (CNT_W)
) i_jas_checker (
  .clk       (clk),
  .rst       (rst),
  .bypass    (bypass),
  .path_sel  (path_sel),
  .rx_stb    (rx_stb),
  .tx_stb    (tx_stb),
  .trip_clr  (trip_clr),
  .out_stb   (out_stb),
  .trip_flag (trip_flag),
  .tick      (fifo_tick),
  .adjust    (trip_set),
  .restart   (restart),
  .cnt       (pace_cnt),
  .last      (pace_last)
);

// File: tb/test_jitter_smoother.sv
module test_jitter_smoother;

  localparam int NOM = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic rst = 1'b1, path_sel = 1'b0, deep_mode = 1'b0, bypass = 1'b0, trip_clr = 1'b0;
  logic rx_bit = 1'b0, rx_stb = 1'b0, tx_bit = 1'b0, tx_stb = 1'b0;
  logic out_bit, out_stb, trip_flag;

  jitter_smoother i_jitter_smoother (
    .clk(clk), .rst(rst), .path_sel(path_sel), .deep_mode(deep_mode),
    .bypass(bypass), .trip_clr(trip_clr), .rx_bit(rx_bit), .rx_stb(rx_stb),
    .tx_bit(tx_bit), .tx_stb(tx_stb), .out_bit(out_bit), .out_stb(out_stb),
    .trip_flag(trip_flag)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  int q[$];
  int exp_period = NOM, last_ev = 0, obs_period = 0;
  bit exp_flag = 0, first_after = 1;
  // values applied on the previous cycle
  bit a_rst = 1, a_path = 0, a_deep = 0, a_byp = 0, a_clr = 0, a_bit = 0, a_stb = 0, a_push = 0;
  // values to apply on the next call of step
  bit n_rst = 0, n_path = 0, n_deep = 0, n_byp = 0, n_clr = 0;
  bit n_rxb = 0, n_rxs = 0, n_txb = 0, n_txs = 0;

  function automatic int depth_of(bit d);
    return d ? 128 : 32;
  endfunction

  function automatic int next_period(int fill, bit d);
    int mar = d ? 8 : 4;
    if (fill > depth_of(d) - mar) return NOM - 1;
    if (fill < mar) return NOM + 1;
    return NOM;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Selected-path write; the other path gets random noise (R1)
  task automatic put(bit s, bit b);
    if (n_path) begin
      n_txs = s; n_txb = b;
      n_rxs = 1'($urandom_range(0, 1)); n_rxb = 1'($urandom_range(0, 1));
    end else begin
      n_rxs = s; n_rxb = b;
      n_txs = 1'($urandom_range(0, 1)); n_txb = 1'($urandom_range(0, 1));
    end
  endtask

  task automatic step();
    bit rec, s_stb, s_bit;
    int fill, v;
    @(negedge clk);
    cyc++;
    // observe the result of the edge just passed
    if (a_rst) begin
      chk(out_stb == 1'b0, "R12 out_stb", out_stb, 0);
    end else if (a_byp) begin
      chk(out_stb == a_stb, "R10 strobe", out_stb, a_stb);
      if (a_stb) chk(out_bit == a_bit, "R10 bit", out_bit, a_bit);
    end else if (out_stb) begin
      obs_period = cyc - last_ev;
      if (first_after)            chk(obs_period == exp_period, "R11 first strobe", obs_period, exp_period);
      else if (exp_period == NOM-1) chk(obs_period == exp_period, "R5 period", obs_period, exp_period);
      else if (exp_period == NOM+1) chk(obs_period == exp_period, "R6 period", obs_period, exp_period);
      else                        chk(obs_period == exp_period, "R4 R7 period", obs_period, exp_period);
      first_after = 0;
      fill = q.size() - (a_push ? 1 : 0);
      if (q.size() == 0) chk(0, "R3 underflow", 0, 1);
      else begin
        v = q.pop_front();
        if (v >= 0) chk(out_bit == v[0], "R1 R2 R3 data", out_bit, v);
      end
      exp_period = next_period(fill, a_deep);
      last_ev = cyc;
      if (exp_period != NOM) exp_flag = 1;
      else if (a_clr) exp_flag = 0;
    end else if (a_clr) exp_flag = 0;
    if (a_rst) exp_flag = 0;
    chk(trip_flag == exp_flag, "R8 flag", trip_flag, exp_flag);
    // apply the next inputs and advance the model
    rec   = n_rst || n_byp || (n_deep != a_deep) || (n_path != a_path);
    s_stb = n_path ? n_txs : n_rxs;
    s_bit = n_path ? n_txb : n_rxb;
    rst = n_rst; path_sel = n_path; deep_mode = n_deep; bypass = n_byp;
    trip_clr = n_clr; rx_bit = n_rxb; rx_stb = n_rxs; tx_bit = n_txb; tx_stb = n_txs;
    if (rec) begin
      q.delete();
      repeat (depth_of(n_deep) / 2) q.push_back(-1);
      last_ev = cyc + 1; exp_period = NOM; first_after = 1; obs_period = 0; a_push = 0;
    end else begin
      a_push = s_stb;
      if (s_stb) q.push_back(int'(s_bit));
    end
    a_rst = n_rst; a_path = n_path; a_deep = n_deep; a_byp = n_byp;
    a_clr = n_clr; a_stb = s_stb; a_bit = s_bit;
    n_clr = 0; n_rxs = 0; n_txs = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    // R12: reset state
    n_rst = 1; repeat (3) step();
    chk(trip_flag == 1'b0, "R12 trip_flag", trip_flag, 0);
    n_rst = 0;

    // R1 R3 R4: shallow store, receive path, one write per slot at a random offset
    for (int s = 0; s < 200; s++) begin
      int off = $urandom_range(0, NOM - 1);
      for (int i = 0; i < NOM; i++) begin
        put(i == off, 1'($urandom_range(0, 1)));
        step();
      end
    end
    chk(trip_flag == 1'b0, "R4 no trip on matched rate", trip_flag, 0);

    // R2 R3: deep store, transmit path, bursts of four writes every 64 cycles
    n_path = 1; n_deep = 1;
    for (int s = 0; s < 50; s++) begin
      for (int i = 0; i < 4 * NOM; i++) begin
        put((i < 8) && (i % 2 == 0), 1'($urandom_range(0, 1)));
        step();
      end
    end
    chk(trip_flag == 1'b0, "R3 no trip on bursty input", trip_flag, 0);

    // R10: bypass on both paths with random traffic
    n_byp = 1;
    for (int i = 0; i < 200; i++) begin
      n_path = (i >= 100);
      put(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      step();
    end
    n_byp = 0;

    // R6 then R9: shallow store starved until a slow period appears
    n_deep = 0;
    for (int i = 0; i < 400 && obs_period != NOM + 1; i++) step();
    chk(obs_period == NOM + 1, "R6 slow period seen", obs_period, NOM + 1);
    chk(trip_flag == 1'b1, "R8 flag after slow period", trip_flag, 1);
    repeat (2) step();
    n_clr = 1; step();
    step();
    chk(trip_flag == 1'b0, "R9 clear mid-period", trip_flag, 0);
    repeat (11) step();
    n_clr = 1; step();
    step();
    chk(out_stb == 1'b1, "R9 strobe on collision edge", out_stb, 1);
    chk(trip_flag == 1'b1, "R9 trip wins over clear", trip_flag, 1);

    // R5: shallow store overfed (a write every 8 cycles) until a fast period
    n_path = 0; n_clr = 1; step();
    for (int i = 0; i < 800 && obs_period != NOM - 1; i++) begin
      put(i % 8 == 0, 1'($urandom_range(0, 1)));
      step();
    end
    chk(obs_period == NOM - 1, "R5 fast period seen (32)", obs_period, NOM - 1);

    // R2 R5: deep store overfed until a fast period
    n_deep = 1;
    for (int i = 0; i < 2000 && obs_period != NOM - 1; i++) begin
      put(i % 8 == 0, 1'($urandom_range(0, 1)));
      step();
    end
    chk(obs_period == NOM - 1, "R2 R5 fast period seen (128)", obs_period, NOM - 1);

    // R6 R11: path change re-centres, then the deep store starves
    n_path = 1;
    for (int i = 0; i < 1500 && obs_period != NOM + 1; i++) step();
    chk(obs_period == NOM + 1, "R6 slow period seen (128)", obs_period, NOM + 1);

    // R12: reset while the flag is set
    n_rst = 1; step(); step();
    chk(trip_flag == 1'b0, "R12 reset clears flag", trip_flag, 0);
    chk(out_stb == 1'b0, "R12 reset clears strobe", out_stb, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule